// File: doc/BRIEF.md
# 8x8 Two-Dimensional DCT, Row-Column Pipeline

This block computes the forward two-dimensional discrete cosine transform of an 8x8 block of unsigned 8-bit pixels, Z = A·X·Aᵀ. A holds the orthonormal cosine basis: A[u][k] = c(u)·cos((2k+1)·u·π/16), where c(0) = √(1/8) and c(u) = 1/2 for u > 0. Pixels arrive one per valid cycle in raster order, row 0 first and column 0 first within a row. Once the last pixel of a block has entered, all 64 coefficients appear at once on a wide output bus, and a one-cycle strobe marks them.

Each pixel is first made signed and then shifted down by 128. A serial row transform multiplies each sample by one column of A. It accumulates for eight samples and emits one 8-value vector per row, flagged by a one-cycle pulse. Eight column units each take one element of that vector and advance only on that pulse. After eight rows they hold the full result. No transpose buffer sits between the stages, so a new block may follow the previous one with no idle cycles.

Top module: `dct2d_8x8`

## Requirements
- R1: Each pixel p is processed as the signed sample p − 128. A block of all 128 yields 64 exact zeros, and a block of all 0 yields coefficient (0,0) = −1024 exactly.
- R2: Coefficient Z[u][v] is the element whose vertical frequency u indexes the input rows and whose horizontal frequency v indexes the columns. It appears as a signed 12-bit value on coef_o[(8·u+v)·12 +: 12]. It is within ±1 of the real-valued sum Σᵢ Σₖ A[u][i]·A[v][k]·(x[i][k] − 128).
- R3: dct_valid_o is high in the fifth cycle after the clock edge that samples the 64th valid pixel of a block.
- R4: dct_valid_o is a single-cycle pulse, raised exactly once for each complete block.
- R5: Blocks streamed back to back, with pix_valid_i held high throughout, each produce their own correct result.
- R6: Cycles with pix_valid_i low are ignored. A block whose pixels are spread out by idle cycles gives the same result as a dense block, and its R3 latency is counted from its last valid pixel.
- R7: coef_o keeps its value in every cycle in which dct_valid_o is low.
- R8: While reset is asserted and after its release, dct_valid_o is low and coef_o is all zeros until the first block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel on pix_i is valid this cycle |
| pix_i | input | 8 | Unsigned pixel, raster order |
| dct_valid_o | output | 1 | One-cycle strobe: coef_o holds a new block |
| coef_o | output | 768 | 64 signed 12-bit coefficients, element (u,v) at bit (8u+v)·12 |

## Verification
The bench uses the default parameters: 8x8 blocks, 8-bit pixels, 14 fractional coefficient bits and 4 fractional bits between the stages. With these values the total fixed-point error stays below one output unit. This makes the ±1 bound against a real-valued reference a sharp test of coefficient signs, of the mapping from column unit to output index, and of rounding. Constant blocks pin down the level shift exactly. Ramp and random blocks streamed with no gaps exercise the reuse of accumulators across block boundaries. Blocks spread out by idle cycles confirm that only valid samples advance the row counters.

// File: rtl/dct_pkg.sv
package dct_pkg;

    // Signed coefficient 0.5*cos(m*pi/16) style basis entry A[u][k], cf fractional bits (cf <= 16)
    function automatic logic signed [31:0] dct_coef(input int u, input int k, input int cf);
        int  m;
        int  mag;
        logic neg;
        m   = ((2 * k + 1) * u) % 32;
        if (m > 16) m = 32 - m;
        if (u == 0) m = 4;
        neg = 1'b0;
        if (m > 8) begin
            neg = 1'b1;
            m   = 16 - m;
        end
        case (m)
            0:       mag = 65536;
            1:       mag = 64277;
            2:       mag = 60547;
            3:       mag = 54491;
            4:       mag = 46341;
            5:       mag = 36410;
            6:       mag = 25080;
            7:       mag = 12785;
            default: mag = 0;
        endcase
        mag = (mag + (1 <<< (16 - cf))) >>> (17 - cf);
        return neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/dct_level_shift.sv
module dct_level_shift #(
    parameter int PIX_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    valid_i,
    input  logic [PIX_W-1:0]        pix_i,
    output logic                    valid_o,
    output logic signed [PIX_W:0]   smp_o
);
    localparam logic signed [PIX_W:0] OFFSET = (PIX_W + 1)'(1 << (PIX_W - 1));

    typedef struct packed {
        logic                  v1;
        logic signed [PIX_W:0] s1;
        logic                  v2;
        logic signed [PIX_W:0] s2;
    } ls_t;

    ls_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.v1 = valid_i;
        st_d.s1 = {1'b0, pix_i};
        st_d.v2 = st_q.v1;
        st_d.s2 = st_q.s1 - OFFSET;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.v2;
    assign smp_o   = st_q.s2;
endmodule

// File: rtl/dct1d_serial.sv
module dct1d_serial
    import dct_pkg::*;
#(
    parameter int N     = 8,
    parameter int IN_W  = 9,
    parameter int OUT_W = 16,
    parameter int CF    = 14,
    parameter int DROP  = 10
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        valid_i,
    input  logic signed [IN_W-1:0]      smp_i,
    output logic                        valid_o,
    output logic [N-1:0][OUT_W-1:0]     vec_o
);
    localparam int KW     = $clog2(N);
    localparam int COEF_W = CF + 2;
    localparam int PROD_W = IN_W + COEF_W;
    localparam int ACC_W  = PROD_W + KW + 1;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (DROP - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

    typedef struct packed {
        logic [KW-1:0]               cnt;
        logic                        prod_vld;
        logic                        prod_last;
        logic [N-1:0][PROD_W-1:0]    prod;
        logic [N-1:0][ACC_W-1:0]     acc;
        logic                        out_vld;
        logic [N-1:0][OUT_W-1:0]     out;
    } u_t;

    u_t st_d, st_q;

    function automatic logic [OUT_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + RND) >>> DROP;
        if (r > MAXV)      return MAXV[OUT_W-1:0];
        else if (r < MINV) return MINV[OUT_W-1:0];
        else               return r[OUT_W-1:0];
    endfunction

    logic signed [PROD_W-1:0] smp_ext;
    logic signed [ACC_W-1:0]  sum [N];

    assign smp_ext = PROD_W'(smp_i);

    always_comb begin
        st_d           = st_q;
        st_d.out_vld   = 1'b0;
        st_d.prod_vld  = valid_i;
        st_d.prod_last = valid_i && (st_q.cnt == KW'(N - 1));
        if (valid_i) begin
            st_d.cnt = (st_q.cnt == KW'(N - 1)) ? '0 : st_q.cnt + 1'b1;
            for (int u = 0; u < N; u++) begin
                st_d.prod[u] = smp_ext * PROD_W'(dct_coef(u, int'(st_q.cnt), CF));
            end
        end
        for (int u = 0; u < N; u++) begin
            sum[u] = $signed(st_q.acc[u]) + ACC_W'($signed(st_q.prod[u]));
        end
        if (st_q.prod_vld) begin
            for (int u = 0; u < N; u++) begin
                if (st_q.prod_last) begin
                    st_d.out[u] = rnd_sat(sum[u]);
                    st_d.acc[u] = '0;
                end else begin
                    st_d.acc[u] = sum[u];
                end
            end
            st_d.out_vld = st_q.prod_last;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign valid_o = st_q.out_vld;
    assign vec_o   = st_q.out;
endmodule

// File: rtl/dct2d_8x8.sv
module dct2d_8x8 #(
    parameter int N         = 8,
    parameter int PIX_W     = 8,
    parameter int COEF_FRAC = 14,
    parameter int MID_FRAC  = 4,
    parameter int MID_W     = 16,
    parameter int OUT_W     = 12
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      pix_valid_i,
    input  logic [PIX_W-1:0]          pix_i,
    output logic                      dct_valid_o,
    output logic [N*N*OUT_W-1:0]      coef_o
);
    localparam int SMP_W = PIX_W + 1;

    logic                       smp_vld;
    logic signed [SMP_W-1:0]    smp;
    logic                       s1_vld;
    logic [N-1:0][MID_W-1:0]    s1_vec;
    logic [N-1:0]               s2_vld;

    dct_level_shift #(.PIX_W(PIX_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (pix_valid_i),
        .pix_i   (pix_i),
        .valid_o (smp_vld),
        .smp_o   (smp)
    );

    dct1d_serial #(
        .N(N), .IN_W(SMP_W), .OUT_W(MID_W), .CF(COEF_FRAC), .DROP(COEF_FRAC - MID_FRAC)
    ) u_row (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (smp_vld),
        .smp_i   (smp),
        .valid_o (s1_vld),
        .vec_o   (s1_vec)
    );

    for (genvar j = 0; j < N; j++) begin : g_col
        logic [N-1:0][OUT_W-1:0] col_out;

        dct1d_serial #(
            .N(N), .IN_W(MID_W), .OUT_W(OUT_W), .CF(COEF_FRAC), .DROP(COEF_FRAC + MID_FRAC)
        ) u_col (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .valid_i (s1_vld),
            .smp_i   ($signed(s1_vec[j])),
            .valid_o (s2_vld[j]),
            .vec_o   (col_out)
        );

        for (genvar v = 0; v < N; v++) begin : g_out
            assign coef_o[(v * N + j) * OUT_W +: OUT_W] = col_out[v];
        end
    end

    assign dct_valid_o = &s2_vld;
endmodule

// File: rtl/dct2d_8x8_chk.sv
module dct2d_8x8_chk #(
    parameter int N     = 8,
    parameter int PIX_W = 8,
    parameter int OUT_W = 12
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     pix_valid_i,
    input logic [PIX_W-1:0]         pix_i,
    input logic                     smp_vld,
    input logic signed [PIX_W:0]    smp,
    input logic                     s1_vld,
    input logic [N-1:0]             s2_vld,
    input logic                     dct_valid_o,
    input logic [N*N*OUT_W-1:0]     coef_o
);
    localparam int OFF = 1 << (PIX_W - 1);

    // R1: sample equals the pixel two cycles back, less the offset
    a_r1_level_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld |-> (int'(smp) == int'($past(pix_i, 2)) - OFF));

    // R6: only valid pixels produce samples
    a_r6_sample_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld |-> $past(pix_valid_i, 2));

    // R3: block strobe follows a row-stage pulse by two cycles
    a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dct_valid_o |-> $past(s1_vld, 2));

    // R4: strobes last one cycle
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dct_valid_o |=> !dct_valid_o);

    a_r4_row_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s1_vld |=> !s1_vld);

    // R4: column units finish together
    a_r4_cols_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s2_vld == '0) || (&s2_vld));

    // R7: output held between strobes
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dct_valid_o |-> $stable(coef_o));
endmodule

bind dct2d_8x8 dct2d_8x8_chk #(.N(N), .PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_valid_i (pix_valid_i),
    .pix_i       (pix_i),
    .smp_vld     (smp_vld),
    .smp         (smp),
    .s1_vld      (s1_vld),
    .s2_vld      (s2_vld),
    .dct_valid_o (dct_valid_o),
    .coef_o      (coef_o)
);

// File: tb/dct2d_8x8_tb.sv
`timescale 1ns/1ps
module dct2d_8x8_tb;
    localparam int N  = 8;
    localparam int NB = N * N;
    localparam int OW = 12;
    localparam int MAXB = 32;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              pix_valid_i = 1'b0;
    logic [7:0]        pix_i = '0;
    logic              dct_valid_o;
    logic [NB*OW-1:0]  coef_o;

    dct2d_8x8 u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
        .dct_valid_o(dct_valid_o), .coef_o(coef_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    real amat [N][N];
    int  blk_pix [MAXB][NB];
    int  exp_cyc [MAXB];
    int  wr_n = 0;
    int  rd_n = 0;
    logic [NB*OW-1:0] last_coef = '0;
    logic prev_valid = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input real act, input real expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0f expected %0f", req, what, act, expv);
        end
    endtask

    function automatic real ref_z(input int b, input int u, input int v);
        real s = 0.0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++)
                s += amat[u][i] * amat[v][k] * real'(blk_pix[b][i*N+k] - 128);
        return s;
    endfunction

    function automatic int hw_z(input int u, input int v);
        logic signed [OW-1:0] t;
        t = coef_o[(u*N+v)*OW +: OW];
        return int'(t);
    endfunction

    // Monitor: R2, R3, R4, R7
    always @(negedge clk) begin
        if (rst_ni) begin
            if (dct_valid_o) begin
                chk(!prev_valid, "R4", "strobe longer than one cycle", 1.0, 0.0);
                if (rd_n >= wr_n) begin
                    chk(1'b0, "R4", "strobe without a block", real'(rd_n), real'(wr_n));
                end else begin
                    chk(cyc == exp_cyc[rd_n], "R3", "strobe cycle", real'(cyc), real'(exp_cyc[rd_n]));
                    begin
                        bit ok = 1'b1;
                        real worst_a = 0.0, worst_e = 0.0;
                        for (int u = 0; u < N; u++)
                            for (int v = 0; v < N; v++) begin
                                real r = ref_z(rd_n, u, v);
                                real d = real'(hw_z(u, v)) - r;
                                if ((d > 1.0 || d < -1.0) && ok) begin
                                    ok = 1'b0; worst_a = real'(hw_z(u, v)); worst_e = r;
                                end
                            end
                        chk(ok, "R2", "coefficient outside +-1", worst_a, worst_e);
                    end
                    rd_n++;
                end
                last_coef = coef_o;
            end else begin
                chk(coef_o == last_coef, "R7", "output changed without strobe", 0.0, 0.0);
            end
            prev_valid = dct_valid_o;
        end
    end

    task automatic send_block(input int px [NB], input bit bubbles);
        for (int n = 0; n < NB; n++) blk_pix[wr_n][n] = px[n];
        for (int n = 0; n < NB; n++) begin
            if (bubbles && (n % 3 == 1)) begin
                @(negedge clk);
                pix_valid_i = 1'b0;
                pix_i = 8'hA5;
            end
            @(negedge clk);
            pix_i = 8'(px[n]);
            pix_valid_i = 1'b1;
            if (n == NB - 1) exp_cyc[wr_n] = cyc + 6;
        end
        wr_n++;
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        pix_valid_i = 1'b0;
        for (int w = 0; w < 20 && rd_n < wr_n; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rd_n == wr_n, req, "strobes versus blocks", real'(rd_n), real'(wr_n));
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        chk(dct_valid_o == 1'b0, "R8", "valid in reset", real'(dct_valid_o), 0.0);
        chk(coef_o == '0, "R8", "coef in reset", 1.0, 0.0);
        rst_ni = 1'b1;
        repeat (4) @(negedge clk);
        chk(dct_valid_o == 1'b0, "R8", "valid after release", real'(dct_valid_o), 0.0);
        chk(coef_o == '0, "R8", "coef after release", 1.0, 0.0);
    endtask

    task automatic t_constant(input int val);
        int px [NB];
        for (int n = 0; n < NB; n++) px[n] = val;
        send_block(px, 1'b0);
        drain("R1");
        if (val == 128) begin
            chk(coef_o == '0, "R1", "mid-grey block not all zero", 1.0, 0.0);
        end
        if (val == 0) begin
            chk(hw_z(0, 0) == -1024, "R1", "black block DC", real'(hw_z(0, 0)), -1024.0);
        end
    endtask

    task automatic t_ramp();
        int px [NB];
        for (int n = 0; n < NB; n++) px[n] = (n / N) * 32 + (n % N) * 3;
        send_block(px, 1'b0);
        drain("R2");
    endtask

    task automatic t_back_to_back();
        int px [NB];
        for (int b = 0; b < 3; b++) begin
            for (int n = 0; n < NB; n++) px[n] = int'($urandom_range(0, 255));
            send_block(px, 1'b0);
        end
        for (int n = 0; n < NB; n++) px[n] = (n % N) * 36;
        send_block(px, 1'b0);
        for (int n = 0; n < NB; n++) px[n] = ((n / N + n % N) % 2 == 0) ? 255 : 0;
        send_block(px, 1'b0);
        drain("R5");
    endtask

    task automatic t_bubbles();
        int px [NB];
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n < NB; n++) px[n] = int'($urandom_range(0, 255));
            send_block(px, 1'b1);
        end
        drain("R6");
    endtask

    initial begin
        for (int u = 0; u < N; u++)
            for (int k = 0; k < N; k++)
                amat[u][k] = ((u == 0) ? $sqrt(1.0 / N) : $sqrt(2.0 / N)) *
                             $cos(real'((2 * k + 1) * u) * 3.14159265358979 / (2.0 * N));
        t_reset();
        t_constant(128);
        t_constant(0);
        t_constant(255);
        t_ramp();
        t_back_to_back();
        t_bubbles();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule